// File: doc/BRIEF.md
# PCI Bus Protocol Violation Monitor

This block is a passive observer attached to the shared PCI signals between a bus interface core and a user IP core. It never drives the bus. On every rising clock edge it samples the bus control lines and decodes the transaction state. The states it tracks are: bus idle, the address phase, each data phase and the last data phase, completed transfers, and the ways a target can end a phase (retry, disconnect with or without data, target abort). A master abort, when no target claims the cycle, is also decoded. A group of timeout counters measures target latency, master wait states, DEVSEL# claim time and bus request duration. A small set of history registers records facts from earlier cycles. These are whether the bus was idle, whether the current transaction is a write, whether the first data phase is still open, whether DEVSEL# has been seen, and whether the transaction was master-aborted.

When a rule is broken, the monitor stores a 6-bit violation code and raises a sticky alert. Host software can read both. Only the first violation after a clear is kept. A one-cycle clear pulse from the host returns the code to zero. All limits are elaboration parameters, so an integrator can set them tighter than the bus protocol allows. The block has no data stream, so every port is a plain level signal with no handshake.

Top module: `pci_rule_monitor`

## Requirements
- R1: After reset, `viol_code` is 0 and `alert` is low.
- R2: An address phase is a clock where FRAME# is asserted and both FRAME# and IRDY# were deasserted on the previous clock. From the next clock, `cmd_write` is 1 when the C/BE# value captured in that phase has bit 0 set and is not 4'b0001. Otherwise it is 0.
- R3: If DEVSEL# is still deasserted on the 5th clock after the address phase (DEVSEL_LIMIT), the code becomes 3 (master abort) on that clock. Asserting DEVSEL# on that clock avoids it.
- R4: If the first data phase has not completed by the 16th clock after the address phase (INIT_LIMIT), the code becomes 2 on the 17th clock.
- R5: After a completed transfer, if the next data phase has not completed within 8 clocks (SUBSEQ_LIMIT), the code becomes 1 on the 9th clock. Bursts that complete in time raise nothing.
- R6: STOP# asserted with DEVSEL# deasserted, after DEVSEL# was asserted earlier in the same transaction, sets the code to 4 (target abort).
- R7: STOP# and TRDY# asserted together in a data phase (disconnect with data) set the code to 5. A retry (STOP# with TRDY# deasserted in the first phase) and a disconnect without data raise nothing.
- R8: If REQ# stays asserted on 33 consecutive clocks (REQ_LIMIT + 1, REQ_LIMIT = 32), the code becomes 6 on the 33rd clock.
- R9: If more than one bit of `drv_en` is high on a clock, the code becomes 7 (contention) on that clock. A single driver raises nothing.
- R10: If IRDY# is deasserted on 9 consecutive data-phase clocks (IRDY_LIMIT + 1, IRDY_LIMIT = 8), the code becomes 8 on the 9th clock.
- R11: Once `alert` is high, later violations leave the code unchanged. A `clr` pulse clears code and alert on that edge, and it wins over a violation seen in the same clock.
- R12: When several violations occur on the same clock, the lowest nonzero code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| stop_n | input | 1 | STOP#, active low |
| req_n | input | 1 | Bus request of the observed master, active low |
| cbe_n | input | 4 | C/BE# lines, carrying the command in the address phase |
| drv_en | input | N_AGENTS | One output-enable per agent on the shared lines |
| clr | input | 1 | Host clear pulse for the latched code and alert |
| cmd_write | output | 1 | Captured command of the current transaction is a write |
| viol_code | output | 6 | Latched violation code (0 = none) |
| alert | output | 1 | Sticky violation flag |

## Verification
Every violation is decided from the bus values sampled at one rising edge. Its code and alert are visible right after that same edge. `cmd_write` is visible right after the address-phase edge. The bench changes inputs at the falling edge and reads outputs at the next falling edge, so each check sees exactly one new rising edge. For every timeout the bench counts clocks from the address phase or from the last transfer. It checks that the alert is still low on the last allowed clock, and that the expected code is present on the following clock.

// File: rtl/pci_mon_pkg.sv
package pci_mon_pkg;
  localparam int CODE_W   = 6;
  localparam int NUM_VIOL = 8;

  typedef enum logic [CODE_W-1:0] {
    VC_NONE   = 6'd0,
    VC_SUBSEQ = 6'd1,
    VC_INIT   = 6'd2,
    VC_MABORT = 6'd3,
    VC_TABORT = 6'd4,
    VC_DISC   = 6'd5,
    VC_REQ    = 6'd6,
    VC_CONT   = 6'd7,
    VC_IRDY   = 6'd8
  } viol_code_e;
endpackage

// File: rtl/pci_mon_decode.sv
module pci_mon_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       devsel_n,
  input  logic       stop_n,
  input  logic [3:0] cbe_n,
  input  logic       mabort,
  output logic       addr_ph,
  output logic       data_ph,
  output logic       xfer,
  output logic       phase_done,
  output logic       first_ph,
  output logic       devsel_seen,
  output logic       tabort,
  output logic       disc_data,
  output logic       cmd_write
);
  // history records
  logic idle_q, txn_q, mahist_q, first_q, dsel_q, wr_q;
  logic idle, stop_hit, retry, disc_nodata, final_ph;

  always_comb begin
    idle        = frame_n & irdy_n;
    addr_ph     = ~frame_n & idle_q;
    data_ph     = txn_q & ~mahist_q;
    xfer        = data_ph & ~irdy_n & ~trdy_n;
    stop_hit    = data_ph & ~stop_n;
    retry       = stop_hit & first_q & trdy_n & ~devsel_n;
    disc_nodata = stop_hit & ~first_q & trdy_n & ~devsel_n;
    tabort      = stop_hit & dsel_q & devsel_n;
    disc_data   = stop_hit & ~trdy_n & ~devsel_n;
    phase_done  = xfer | retry | disc_nodata | tabort;
    final_ph    = data_ph & frame_n & ~irdy_n;
  end

  assign first_ph    = first_q;
  assign devsel_seen = dsel_q;
  assign cmd_write   = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q   <= 1'b0;
      txn_q    <= 1'b0;
      mahist_q <= 1'b0;
      first_q  <= 1'b0;
      dsel_q   <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      idle_q <= idle;
      if (addr_ph) begin
        txn_q    <= 1'b1;
        mahist_q <= 1'b0;
        first_q  <= 1'b1;
        dsel_q   <= 1'b0;
        wr_q     <= cbe_n[0] & (cbe_n[3:1] != 3'b000);
      end else begin
        if (idle || (final_ph && phase_done)) txn_q <= 1'b0;
        if (mabort)                         mahist_q <= 1'b1;
        if (data_ph && phase_done)          first_q <= 1'b0;
        if (data_ph && !devsel_n)           dsel_q <= 1'b1;
      end
    end
  end

  // R2: an address phase is only recognised after an idle clock
  a_r2_addr_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |-> $past(frame_n & irdy_n));

  // R5: once a phase completes, the first-phase record is dropped
  a_r5_first_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && phase_done) |=> !first_ph);
endmodule

// File: rtl/pci_mon_timers.sv
module pci_mon_timers #(
  parameter int DEVSEL_LIMIT = 5,
  parameter int INIT_LIMIT   = 16,
  parameter int SUBSEQ_LIMIT = 8,
  parameter int IRDY_LIMIT   = 8,
  parameter int REQ_LIMIT    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_ph,
  input  logic data_ph,
  input  logic phase_done,
  input  logic first_ph,
  input  logic devsel_seen,
  input  logic devsel_n,
  input  logic irdy_n,
  input  logic req_n,
  output logic mabort,
  output logic viol_init,
  output logic viol_subseq,
  output logic viol_irdy,
  output logic viol_req
);
  localparam int WAIT_MAX = (INIT_LIMIT > SUBSEQ_LIMIT) ? INIT_LIMIT : SUBSEQ_LIMIT;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int DCNT_W   = $clog2(DEVSEL_LIMIT + 1);
  localparam int ICNT_W   = $clog2(IRDY_LIMIT + 1);
  localparam int RCNT_W   = $clog2(REQ_LIMIT + 1);

  logic [DCNT_W-1:0] dcnt;
  logic [WAIT_W-1:0] wcnt;
  logic [ICNT_W-1:0] icnt;
  logic [RCNT_W-1:0] rcnt;
  logic              claim_wait;

  always_comb begin
    claim_wait  = data_ph & devsel_n & ~devsel_seen;
    mabort      = claim_wait & (dcnt == DCNT_W'(DEVSEL_LIMIT - 1));
    viol_init   = data_ph & first_ph & ~phase_done & (wcnt == WAIT_W'(INIT_LIMIT));
    viol_subseq = data_ph & ~first_ph & ~phase_done & (wcnt == WAIT_W'(SUBSEQ_LIMIT));
    viol_irdy   = data_ph & irdy_n & (icnt == ICNT_W'(IRDY_LIMIT));
    viol_req    = ~req_n & (rcnt == RCNT_W'(REQ_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      wcnt <= '0;
      icnt <= '0;
      rcnt <= '0;
    end else begin
      // DEVSEL# claim window
      if (addr_ph)
        dcnt <= '0;
      else if (claim_wait && dcnt != DCNT_W'(DEVSEL_LIMIT - 1))
        dcnt <= dcnt + 1'b1;
      // per-phase target latency
      if (addr_ph || (data_ph && phase_done))
        wcnt <= '0;
      else if (data_ph && wcnt != WAIT_W'(WAIT_MAX))
        wcnt <= wcnt + 1'b1;
      // master wait states
      if (data_ph && irdy_n) begin
        if (icnt != ICNT_W'(IRDY_LIMIT)) icnt <= icnt + 1'b1;
      end else begin
        icnt <= '0;
      end
      // bus request duration
      if (!req_n) begin
        if (rcnt != RCNT_W'(REQ_LIMIT)) rcnt <= rcnt + 1'b1;
      end else begin
        rcnt <= '0;
      end
    end
  end

  // R8: a request violation needs the request held on the clock before
  a_r8_req_run: assert property (@(posedge clk) disable iff (!rst_n)
    viol_req |-> $past(!req_n));

  // R3: a master abort follows a clock with no target claim
  a_r3_no_claim_before: assert property (@(posedge clk) disable iff (!rst_n)
    mabort |-> $past(devsel_n));
endmodule

// File: rtl/pci_mon_latch.sv
module pci_mon_latch
  import pci_mon_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_VIOL:1]   viol,
  input  logic                clr,
  output logic [CODE_W-1:0]   code,
  output logic                alert
);
  logic [CODE_W-1:0] sel;

  // lowest code number wins
  always_comb begin
    sel = VC_NONE;
    for (int i = NUM_VIOL; i >= 1; i--) begin
      if (viol[i]) sel = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= VC_NONE;
      alert <= 1'b0;
    end else if (clr) begin
      code  <= VC_NONE;
      alert <= 1'b0;
    end else if (!alert && sel != VC_NONE) begin
      code  <= sel;
      alert <= 1'b1;
    end
  end

  // R11: a latched code holds until a clear
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && !clr) |=> (alert && $stable(code)));

  // R11: a clear always empties the latch
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!alert && code == VC_NONE));
endmodule

// File: rtl/pci_rule_monitor.sv
module pci_rule_monitor
  import pci_mon_pkg::*;
#(
  parameter int N_AGENTS     = 2,
  parameter int DEVSEL_LIMIT = 5,
  parameter int INIT_LIMIT   = 16,
  parameter int SUBSEQ_LIMIT = 8,
  parameter int IRDY_LIMIT   = 8,
  parameter int REQ_LIMIT    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                trdy_n,
  input  logic                devsel_n,
  input  logic                stop_n,
  input  logic                req_n,
  input  logic [3:0]          cbe_n,
  input  logic [N_AGENTS-1:0] drv_en,
  input  logic                clr,
  output logic                cmd_write,
  output logic [CODE_W-1:0]   viol_code,
  output logic                alert
);
  logic addr_ph, data_ph, xfer, phase_done, first_ph, devsel_seen;
  logic tabort, disc_data, mabort;
  logic viol_init, viol_subseq, viol_irdy, viol_req, contention;
  logic [NUM_VIOL:1] viol;

  pci_mon_decode u_decode (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .cbe_n(cbe_n),
    .mabort(mabort), .addr_ph(addr_ph), .data_ph(data_ph), .xfer(xfer),
    .phase_done(phase_done), .first_ph(first_ph), .devsel_seen(devsel_seen),
    .tabort(tabort), .disc_data(disc_data), .cmd_write(cmd_write)
  );

  pci_mon_timers #(
    .DEVSEL_LIMIT(DEVSEL_LIMIT), .INIT_LIMIT(INIT_LIMIT),
    .SUBSEQ_LIMIT(SUBSEQ_LIMIT), .IRDY_LIMIT(IRDY_LIMIT), .REQ_LIMIT(REQ_LIMIT)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .addr_ph(addr_ph), .data_ph(data_ph),
    .phase_done(phase_done), .first_ph(first_ph), .devsel_seen(devsel_seen),
    .devsel_n(devsel_n), .irdy_n(irdy_n), .req_n(req_n), .mabort(mabort),
    .viol_init(viol_init), .viol_subseq(viol_subseq), .viol_irdy(viol_irdy),
    .viol_req(viol_req)
  );

  always_comb begin
    contention        = ($countones(drv_en) > 1);
    viol              = '0;
    viol[VC_SUBSEQ]   = viol_subseq;
    viol[VC_INIT]     = viol_init;
    viol[VC_MABORT]   = mabort;
    viol[VC_TABORT]   = tabort;
    viol[VC_DISC]     = disc_data;
    viol[VC_REQ]      = viol_req;
    viol[VC_CONT]     = contention;
    viol[VC_IRDY]     = viol_irdy;
  end

  pci_mon_latch u_latch (
    .clk(clk), .rst_n(rst_n), .viol(viol), .clr(clr),
    .code(viol_code), .alert(alert)
  );

  // R11: any violation without a clear leaves the alert raised
  a_r11_alert_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((|viol) && !clr) |=> alert);

  // R5: a completed transfer never coincides with a latency violation
  a_r5_xfer_no_latency: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> !(viol_init || viol_subseq));
endmodule

// File: tb/pci_rule_monitor_tb_top.sv
module pci_rule_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, frame_n, irdy_n, trdy_n, devsel_n, stop_n, req_n, clr;
  logic [3:0] cbe_n;
  logic [1:0] drv_en;
  logic       cmd_write, alert;
  logic [5:0] viol_code;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pci_rule_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .req_n(req_n),
    .cbe_n(cbe_n), .drv_en(drv_en), .clr(clr), .cmd_write(cmd_write),
    .viol_code(viol_code), .alert(alert)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    frame_n = 1; irdy_n = 1; trdy_n = 1; devsel_n = 1; stop_n = 1;
    req_n = 1; cbe_n = 4'h0; drv_en = 2'b00; clr = 0;
  endtask

  task automatic recover();
    bus_idle(); clr = 1; cyc(); clr = 0; cyc();
  endtask

  task automatic begin_txn(logic [3:0] cmd);
    frame_n = 0; cbe_n = cmd; irdy_n = 1; cyc();
    irdy_n = 0; cbe_n = 4'h0;
  endtask

  task automatic finish_txn();
    devsel_n = 0; trdy_n = 0; stop_n = 1; frame_n = 1; irdy_n = 0; cyc();
    bus_idle(); cyc();
  endtask

  task automatic t_r2_commands();
    begin_txn(4'b0111);
    chk("R2 write command", {5'd0, cmd_write}, 6'd1);
    devsel_n = 0; trdy_n = 0; cyc();
    frame_n = 1; cyc();
    bus_idle(); cyc();
    chk("R5 clean burst no alert", viol_code, 6'd0);
    begin_txn(4'b0110);
    chk("R2 read command", {5'd0, cmd_write}, 6'd0);
    finish_txn();
    begin_txn(4'b0001);
    chk("R2 special cycle not write", {5'd0, cmd_write}, 6'd0);
    finish_txn();
  endtask

  task automatic t_r3_master_abort();
    begin_txn(4'b0110);
    for (int i = 1; i <= 5; i++) begin
      cyc();
      if (i == 4) chk("R3 no abort on 4th clock", {5'd0, alert}, 6'd0);
      if (i == 5) chk("R3 master abort code", viol_code, 6'd3);
    end
    frame_n = 1; cyc(); bus_idle(); cyc();
    recover();
  endtask

  task automatic t_r4_initial();
    begin_txn(4'b0110);
    for (int i = 1; i <= 17; i++) begin
      devsel_n = (i < 5);
      cyc();
      if (i == 16) chk("R3/R4 late claim ok, 16th clock quiet", {5'd0, alert}, 6'd0);
      if (i == 17) chk("R4 initial latency code", viol_code, 6'd2);
    end
    finish_txn();
    recover();
  endtask

  task automatic t_r5_subsequent();
    begin_txn(4'b0111);
    devsel_n = 0; trdy_n = 0; cyc();
    trdy_n = 1;
    for (int i = 1; i <= 9; i++) begin
      cyc();
      if (i == 8) chk("R5 8th wait clock quiet", {5'd0, alert}, 6'd0);
      if (i == 9) chk("R5 subsequent latency code", viol_code, 6'd1);
    end
    finish_txn();
    recover();
  endtask

  task automatic t_r6_target_abort();
    begin_txn(4'b0110);
    devsel_n = 0; trdy_n = 0; cyc();
    devsel_n = 1; trdy_n = 1; stop_n = 0; cyc();
    chk("R6 target abort code", viol_code, 6'd4);
    frame_n = 1; cyc(); bus_idle(); cyc();
    recover();
  endtask

  task automatic t_r7_stops();
    begin_txn(4'b0110);
    devsel_n = 0; trdy_n = 0; stop_n = 0; cyc();
    chk("R7 disconnect with data code", viol_code, 6'd5);
    frame_n = 1; cyc(); bus_idle(); cyc();
    recover();
    begin_txn(4'b0110);
    devsel_n = 0; trdy_n = 1; stop_n = 0; cyc();
    frame_n = 1; cyc();
    bus_idle(); cyc();
    chk("R7 retry and disconnect without data quiet", {5'd0, alert}, 6'd0);
  endtask

  task automatic t_r8_request();
    req_n = 0;
    for (int i = 1; i <= 33; i++) begin
      cyc();
      if (i == 32) chk("R8 32nd request clock quiet", {5'd0, alert}, 6'd0);
      if (i == 33) chk("R8 request held code", viol_code, 6'd6);
    end
    recover();
  endtask

  task automatic t_r9_r11_contention();
    drv_en = 2'b01; cyc();
    chk("R9 single driver quiet", {5'd0, alert}, 6'd0);
    drv_en = 2'b11; cyc();
    chk("R9 contention code", viol_code, 6'd7);
    drv_en = 2'b00;
    begin_txn(4'b0110);
    devsel_n = 0; trdy_n = 0; stop_n = 0; cyc();
    chk("R11 first code kept", viol_code, 6'd7);
    frame_n = 1; cyc(); bus_idle(); cyc();
    clr = 1; drv_en = 2'b11; cyc();
    chk("R11 clear wins over new violation", {alert, viol_code[4:0]}, 6'd0);
    clr = 0; drv_en = 2'b00; cyc();
    chk("R11 stays clear", viol_code, 6'd0);
  endtask

  task automatic t_r10_irdy();
    begin_txn(4'b0111);
    irdy_n = 1; devsel_n = 0; trdy_n = 0;
    for (int i = 1; i <= 9; i++) begin
      cyc();
      if (i == 8) chk("R10 8th wait clock quiet", {5'd0, alert}, 6'd0);
      if (i == 9) chk("R10 IRDY# timeout code", viol_code, 6'd8);
    end
    finish_txn();
    recover();
  endtask

  task automatic t_r12_priority();
    begin_txn(4'b0110);
    devsel_n = 0; trdy_n = 0; stop_n = 0; drv_en = 2'b11; cyc();
    chk("R12 lowest code wins", viol_code, 6'd5);
    drv_en = 2'b00; frame_n = 1; cyc(); bus_idle(); cyc();
    recover();
  endtask

  initial begin
    bus_idle();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 reset code", viol_code, 6'd0);
    chk("R1 reset alert", {5'd0, alert}, 6'd0);
    t_r2_commands();
    t_r3_master_abort();
    t_r4_initial();
    t_r5_subsequent();
    t_r6_target_abort();
    t_r7_stops();
    t_r8_request();
    t_r9_r11_contention();
    t_r10_irdy();
    t_r12_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule